// File: doc/BRIEF.md
# Bitmap Layer Pixel Fetch Generator

This block turns a beam position into a memory request for a bitmap display layer where every pixel is stored on its own. Three storage modes are supported. The first is 256x192 at one byte per pixel, stored line by line. The second is 320x256 at one byte per pixel, stored column by column. The third is 640x256 at four bits per pixel, using the same column layout but with two pixels packed into each byte.

For each request the block does three things. It first shifts the beam coordinates by the scroll values and wraps them inside the current mode's frame. It then forms a linear byte address from the wrapped coordinates. Finally, it splits that address into a 16 KiB bank number, counted from a display base bank, and a 14-bit offset inside the bank.

When the read data returns, the block forms an 8-bit palette index. In the 8-bit modes it adds the 4-bit palette offset to the pixel's top four bits. In the 4-bit mode it first picks one nibble of the byte and then adds the offset.

Top module: `bmp_fetch_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `addr_valid` and `pix_valid` are low. `addr_bank`, `addr_ofs` and `pix_index` all read zero.
- R2: Mode code 0 (and the spare code 3) selects 256x192 line order. The wrapped coordinates are xs=(beam_x+scroll_x) mod 256 and ys=(beam_y+scroll_y) mod 192. The linear address is ys*256+xs. Scroll values must be smaller than the frame size.
- R3: Mode code 1 selects 320x256 column order. The wrapped coordinates are xs=(beam_x+scroll_x) mod 320 and ys=(beam_y+scroll_y) mod 256. The linear address is xs*256+ys, so the frame spans five banks.
- R4: Mode code 2 selects 640x256 packed order. The wrapped coordinates are xs=(beam_x+scroll_x) mod 640 and ys=(beam_y+scroll_y) mod 256. The linear address is (xs/2)*256+ys.
- R5: A request sampled with `req_valid` high at a clock edge shows up on `addr_valid`, `addr_bank` and `addr_ofs` right after that edge, one cycle later. `addr_ofs` is the linear address mod 16384.
- R6: `addr_bank` = (base_bank + linear address / 16384) mod 256.
- R7: In modes 0, 1 and 3, pix_index[7:4] = (rd_data[7:4]+pal_ofs) mod 16 and pix_index[3:0] = rd_data[3:0].
- R8: In mode 2, an even xs selects rd_data[7:4] and an odd xs selects rd_data[3:0]. pix_index = {pal_ofs, selected nibble}.
- R9: Read data is expected RD_LAT cycles after its address appears. `pix_valid` rises one cycle after `rd_valid` is sampled. The mode and nibble choice come from the request that produced the address, not from the current mode input.
- R10: `base_bank` is sampled with each request, so a change between requests takes effect at the next request and leaves returning pixels unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Beam request strobe |
| beam_x | input | 10 | Beam pixel column |
| beam_y | input | 9 | Beam pixel line |
| mode | input | 2 | Storage mode code |
| base_bank | input | 8 | Display base bank |
| scroll_x | input | 10 | Horizontal pixel shift |
| scroll_y | input | 9 | Vertical pixel shift |
| pal_ofs | input | 4 | Palette offset |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | 8 | Read data byte |
| addr_valid | output | 1 | Address strobe |
| addr_bank | output | 8 | 16 KiB bank number |
| addr_ofs | output | 14 | Offset within bank |
| pix_valid | output | 1 | Palette index strobe |
| pix_index | output | 8 | Palette index |

## Verification
A new address request and the pixel return for an older request can land on the same clock edge. The bench forces this on purpose. It issues a 4-bit-mode request at an odd column, and on the edge where that request's data comes back it issues a fresh request with a different mode and base bank. Both outputs are checked after that edge. The returned pixel must still use the low nibble and the packed-mode offset rule, and the new address must follow the new mode and base.

// File: rtl/bmp_pkg.sv
`timescale 1ns/1ps
package bmp_pkg;
  typedef enum logic [1:0] {
    BM_ROW8 = 2'd0,
    BM_COL8 = 2'd1,
    BM_COL4 = 2'd2,
    BM_RSVD = 2'd3
  } bmp_mode_e;

  localparam int XW   = 10;
  localparam int YW   = 8;
  localparam int LINW = 17;
  localparam int BANK_SHIFT = 14;

  function automatic logic [XW:0] span_x(bmp_mode_e m);
    case (m)
      BM_COL8: span_x = (XW+1)'(320);
      BM_COL4: span_x = (XW+1)'(640);
      default: span_x = (XW+1)'(256);
    endcase
  endfunction

  function automatic logic [YW:0] span_y(bmp_mode_e m);
    case (m)
      BM_COL8, BM_COL4: span_y = (YW+1)'(256);
      default:          span_y = (YW+1)'(192);
    endcase
  endfunction
endpackage

// File: rtl/bmp_wrap.sv
`timescale 1ns/1ps
module bmp_wrap #(
  parameter int W = 10
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] shift,
  input  logic [W:0]   span,
  output logic [W-1:0] wrapped
);
  logic [W:0] sum;
  logic [W:0] diff;

  always_comb begin
    sum  = {1'b0, pos} + {1'b0, shift};
    diff = sum - span;
    wrapped = (sum >= span) ? diff[W-1:0] : sum[W-1:0];
  end
endmodule

// File: rtl/bmp_addr_map.sv
`timescale 1ns/1ps
module bmp_addr_map
  import bmp_pkg::*;
#(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  bmp_mode_e         mode,
  input  logic [XW-1:0]     xs,
  input  logic [YW-1:0]     ys,
  input  logic [BANK_W-1:0] base,
  output logic              addr_valid,
  output logic [BANK_W-1:0] bank,
  output logic [BANK_SHIFT-1:0] ofs,
  output logic              sel4,
  output logic              nib_lo
);
  localparam int HI_W = LINW - BANK_SHIFT;

  logic [LINW-1:0]   lin;
  logic [BANK_W-1:0] bank_n;

  always_comb begin
    case (mode)
      BM_COL8: lin = {xs[8:0], ys};
      BM_COL4: lin = {xs[9:1], ys};
      default: lin = {1'b0, ys, xs[7:0]};
    endcase
    bank_n = base + {{(BANK_W-HI_W){1'b0}}, lin[LINW-1:BANK_SHIFT]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      bank       <= '0;
      ofs        <= '0;
      sel4       <= 1'b0;
      nib_lo     <= 1'b0;
    end else begin
      addr_valid <= req_valid;
      if (req_valid) begin
        bank   <= bank_n;
        ofs    <= lin[BANK_SHIFT-1:0];
        sel4   <= (mode == BM_COL4);
        nib_lo <= xs[0];
      end
    end
  end

  AST_ADDR_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> addr_valid); // R5
  AST_ROW_BANK_SPAN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (mode == BM_ROW8)) |=> (BANK_W'(bank - $past(base)) < BANK_W'(3))); // R2
  AST_COL_BANK_SPAN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (mode == BM_COL8)) |=> (BANK_W'(bank - $past(base)) < BANK_W'(5))); // R3
endmodule

// File: rtl/bmp_pix_unpack.sv
`timescale 1ns/1ps
module bmp_pix_unpack #(
  parameter int PW = 8,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_valid,
  input  logic [PW-1:0] rd_data,
  input  logic          sel4,
  input  logic          nib_lo,
  input  logic [OW-1:0] pal_ofs,
  output logic          pix_valid,
  output logic [PW-1:0] pix_index
);
  localparam int NW = PW / 2;

  logic [NW-1:0] nib;
  logic [PW-1:0] raw;
  logic [PW-1:0] idx_n;

  always_comb begin
    nib   = nib_lo ? rd_data[NW-1:0] : rd_data[PW-1:NW];
    raw   = sel4 ? {{NW{1'b0}}, nib} : rd_data;
    idx_n = {raw[PW-1:NW] + pal_ofs, raw[NW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_index <= '0;
    end else begin
      pix_valid <= rd_valid;
      if (rd_valid) pix_index <= idx_n;
    end
  end

  AST_PIX_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> pix_valid); // R9
  AST_PIX_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> $past(rd_valid)); // R9
  AST_PACKED_UPPER: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && sel4) |=> (pix_index[PW-1:NW] == $past(pal_ofs))); // R8
  AST_BYTE_LOW_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !sel4) |=> (pix_index[NW-1:0] == $past(rd_data[NW-1:0]))); // R7
endmodule

// File: rtl/bmp_fetch_gen.sv
`timescale 1ns/1ps
module bmp_fetch_gen
  import bmp_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [9:0]        beam_x,
  input  logic [8:0]        beam_y,
  input  logic [1:0]        mode,
  input  logic [BANK_W-1:0] base_bank,
  input  logic [9:0]        scroll_x,
  input  logic [8:0]        scroll_y,
  input  logic [3:0]        pal_ofs,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              addr_valid,
  output logic [BANK_W-1:0] addr_bank,
  output logic [13:0]       addr_ofs,
  output logic              pix_valid,
  output logic [7:0]        pix_index
);
  bmp_mode_e     mode_e;
  logic [XW-1:0] xs;
  logic [YW-1:0] ys;
  logic [YW:0]   y_pos;
  logic [YW:0]   y_shift;
  logic [YW:0]   ys_full;
  logic          sel4_a, nib_a;
  logic [1:0]    tag_tail;

  assign mode_e  = bmp_mode_e'(mode);
  assign y_pos   = beam_y;
  assign y_shift = scroll_y;

  bmp_wrap #(.W(XW)) u_wrap_x (
    .pos(beam_x), .shift(scroll_x), .span(span_x(mode_e)), .wrapped(xs)
  );

  bmp_wrap #(.W(YW+1)) u_wrap_y (
    .pos(y_pos), .shift(y_shift), .span({1'b0, span_y(mode_e)}), .wrapped(ys_full)
  );

  assign ys = ys_full[YW-1:0];

  bmp_addr_map #(.BANK_W(BANK_W)) u_map (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode_e),
    .xs(xs), .ys(ys), .base(base_bank),
    .addr_valid(addr_valid), .bank(addr_bank), .ofs(addr_ofs),
    .sel4(sel4_a), .nib_lo(nib_a)
  );

  generate
    if (RD_LAT > 1) begin : g_dly
      logic [1:0] dly [RD_LAT-1];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < RD_LAT-1; i++) dly[i] <= 2'b00;
        end else begin
          dly[0] <= {sel4_a, nib_a};
          for (int i = 1; i < RD_LAT-1; i++) dly[i] <= dly[i-1];
        end
      end
      assign tag_tail = dly[RD_LAT-2];
    end else begin : g_nodly
      assign tag_tail = {sel4_a, nib_a};
    end
  endgenerate

  bmp_pix_unpack #(.PW(8), .OW(4)) u_pix (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_data(rd_data),
    .sel4(tag_tail[1]), .nib_lo(tag_tail[0]), .pal_ofs(pal_ofs),
    .pix_valid(pix_valid), .pix_index(pix_index)
  );

  AST_Y_WRAPPED: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (ys_full[YW] == 1'b0)); // R2
endmodule

// File: tb/tb_bmp_fetch_gen.sv
`timescale 1ns/1ps
module tb_bmp_fetch_gen;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst;
  logic req_valid;
  logic [9:0] beam_x;
  logic [8:0] beam_y;
  logic [1:0] mode;
  logic [7:0] base_bank;
  logic [9:0] scroll_x;
  logic [8:0] scroll_y;
  logic [3:0] pal_ofs;
  logic rd_valid;
  logic [7:0] rd_data;
  logic addr_valid;
  logic [7:0] addr_bank;
  logic [13:0] addr_ofs;
  logic pix_valid;
  logic [7:0] pix_index;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bmp_fetch_gen #(.BANK_W(8), .RD_LAT(LAT)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .beam_x(beam_x), .beam_y(beam_y),
    .mode(mode), .base_bank(base_bank), .scroll_x(scroll_x), .scroll_y(scroll_y),
    .pal_ofs(pal_ofs), .rd_valid(rd_valid), .rd_data(rd_data),
    .addr_valid(addr_valid), .addr_bank(addr_bank), .addr_ofs(addr_ofs),
    .pix_valid(pix_valid), .pix_index(pix_index)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wx(int m, int x, int sx);
    int w = (m == 1) ? 320 : (m == 2) ? 640 : 256;
    return (x + sx) % w;
  endfunction

  function automatic int wy(int m, int y, int sy);
    int h = (m == 1 || m == 2) ? 256 : 192;
    return (y + sy) % h;
  endfunction

  function automatic int lin_of(int m, int x, int y, int sx, int sy);
    int xs = wx(m, x, sx);
    int ys = wy(m, y, sy);
    if (m == 1) return xs * 256 + ys;
    if (m == 2) return (xs / 2) * 256 + ys;
    return ys * 256 + xs;
  endfunction

  function automatic int pix_of(int m, int xs, int d, int o);
    int n;
    if (m == 2) begin
      n = (xs % 2 == 0) ? d / 16 : d % 16;
      return o * 16 + n;
    end
    return (((d / 16) + o) % 16) * 16 + (d % 16);
  endfunction

  task automatic idle_inputs();
    req_valid = 0; rd_valid = 0; rd_data = 0;
  endtask

  task automatic drive_req(int m, int x, int y, int sx, int sy, int b);
    req_valid = 1; mode = 2'(m); beam_x = 10'(x); beam_y = 9'(y);
    scroll_x = 10'(sx); scroll_y = 9'(sy); base_bank = 8'(b);
  endtask

  task automatic check_addr(string req, int m, int x, int y, int sx, int sy, int b);
    int lin = lin_of(m, x, y, sx, sy);
    check({req, " addr_valid"}, int'(addr_valid), 1);
    check({req, " bank"}, int'(addr_bank), (b + lin / 16384) % 256);
    check({req, " ofs"}, int'(addr_ofs), lin % 16384);
  endtask

  // One request then its read return; address and pixel both checked
  task automatic run_one(string req, int m, int x, int y, int sx, int sy, int b, int d, int o);
    @(negedge clk);
    drive_req(m, x, y, sx, sy, b);
    @(negedge clk);
    req_valid = 0;
    check_addr(req, m, x, y, sx, sy, b);
    repeat (LAT - 1) @(negedge clk);
    rd_valid = 1; rd_data = 8'(d); pal_ofs = 4'(o);
    check({req, " pix_valid before edge"}, int'(pix_valid), 0);
    @(negedge clk);
    rd_valid = 0;
    check({req, " pix_valid"}, int'(pix_valid), 1);
    check({req, " pix_index"}, int'(pix_index), pix_of(m, wx(m, x, sx), d, o));
    @(negedge clk);
    check({req, " pix_valid drop"}, int'(pix_valid), 0);
  endtask

  task automatic test_reset();
    rst = 1; idle_inputs();
    drive_req(0, 3, 3, 0, 0, 5); rd_valid = 1; rd_data = 8'hFF; pal_ofs = 4'hF;
    repeat (3) @(negedge clk);
    check("R1 addr_valid in reset", int'(addr_valid), 0);
    check("R1 pix_valid in reset", int'(pix_valid), 0);
    check("R1 bank in reset", int'(addr_bank), 0);
    check("R1 ofs in reset", int'(addr_ofs), 0);
    check("R1 index in reset", int'(pix_index), 0);
    idle_inputs();
    rst = 0;
    @(negedge clk);
    check("R1 addr_valid after reset", int'(addr_valid), 0);
    check("R1 pix_valid after reset", int'(pix_valid), 0);
  endtask

  task automatic test_row_mode();
    run_one("R2 R5 row plain", 0, 10, 70, 0, 0, 9, 8'h5A, 0);
    run_one("R2 row scroll wrap", 0, 250, 190, 10, 5, 9, 8'h12, 1);
    run_one("R2 spare code", 3, 255, 191, 0, 0, 20, 8'h80, 3);
  endtask

  task automatic test_col_mode();
    run_one("R3 col corner", 1, 319, 255, 0, 0, 16, 8'h00, 0);
    run_one("R3 col scroll wrap", 1, 300, 250, 30, 20, 16, 8'h3C, 0);
    run_one("R6 bank wrap", 1, 200, 7, 0, 0, 254, 8'h11, 0);
  endtask

  task automatic test_pixels();
    run_one("R7 offset carry drop", 1, 5, 5, 0, 0, 0, 8'hA5, 9);
    run_one("R4 R8 even high nibble", 2, 4, 9, 0, 0, 30, 8'hC3, 2);
    run_one("R4 R8 odd low nibble", 2, 639, 255, 0, 0, 30, 8'hC3, 2);
    run_one("R4 packed scroll wrap", 2, 630, 100, 15, 200, 30, 8'h7E, 15);
  endtask

  // Old request's data returns on the same edge as a new request
  task automatic test_overlap();
    @(negedge clk);
    drive_req(2, 101, 40, 0, 0, 12);
    @(negedge clk);
    req_valid = 0;
    check_addr("R4 overlap first", 2, 101, 40, 0, 0, 12);
    repeat (LAT - 1) @(negedge clk);
    rd_valid = 1; rd_data = 8'h9B; pal_ofs = 4'h6;
    drive_req(1, 64, 3, 0, 0, 40);
    @(negedge clk);
    rd_valid = 0; req_valid = 0;
    check("R9 overlap pix_valid", int'(pix_valid), 1);
    check("R9 overlap packed nibble kept", int'(pix_index), 8'h6B);
    check_addr("R10 overlap new base", 1, 64, 3, 0, 0, 40);
    base_bank = 8'd77;
    repeat (LAT - 1) @(negedge clk);
    rd_valid = 1; rd_data = 8'h9B; pal_ofs = 4'h6;
    @(negedge clk);
    rd_valid = 0;
    check("R9 second pix byte mode", int'(pix_index), 8'hFB);
    check("R10 bank held between requests", int'(addr_bank), 41);
  endtask

  initial begin
    idle_inputs();
    mode = 0; beam_x = 0; beam_y = 0; base_bank = 0;
    scroll_x = 0; scroll_y = 0; pal_ofs = 0;
    test_reset();
    test_row_mode();
    test_col_mode();
    test_pixels();
    test_overlap();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule